// File: doc/BRIEF.md
# Non-Preemptive Hardware Thread Scheduler

This block decides which of eight hardware thread contexts owns a single in-order issue pipeline. Each context is always in exactly one of three states: ready to run, active (owning the pipeline), or waiting on a completion signal from memory or a peripheral. The active context keeps the pipeline until it yields on its own. When it yields it says whether it parks as waiting (the usual case, after it issues an off-chip access) or goes straight back to ready. The scheduler then picks the next owner round-robin among the ready contexts, starting just after the context that yielded. It charges a fixed bubble of `SWITCH_CYCLES` cycles (default 4) before the new owner may issue.

A waiting context becomes ready again only on its own completion pulse. If nothing is ready when a yield happens, the scheduler idles with the pipeline-valid output low. The first context to become ready is then granted and pays the same switch bubble. A completion pulse for a context that is not waiting changes nothing, and one cycle later it raises an error pulse.

The scheduler has three named states. RUN: a context owns the pipeline and valid is high. SWITCH: the switch bubble is being counted down. IDLE: no context is ready. The transitions are as follows. YIELD_GO goes from RUN to SWITCH when a yield finds a candidate. YIELD_EMPTY goes from RUN to IDLE when a yield finds none. WAKE goes from IDLE to SWITCH when a context becomes ready. BUBBLE_DONE goes from SWITCH to RUN when the count expires.

Top module: `hw_thread_sched`

## Requirements
- R1: After reset, context 0 is active, all other contexts are ready, `pipe_valid_o` is 1, `active_id_o` is 0 and `done_err_o` is 0.
- R2: `ctx_state_o[2i+1:2i]` gives the state of context i, encoded as 0 = ready, 1 = waiting and 2 = active. At most one context is active at any time.
- R3: While valid is high, the owner keeps the pipeline as long as `yield_i[active_id_o]` is low. Yield bits of other contexts, and `wait_i` bits without a matching yield, have no effect.
- R4: When the owner yields, it becomes waiting if `wait_i[active_id_o]` is 1 in the same cycle, and ready otherwise.
- R5: After a yield cycle that finds a candidate, `pipe_valid_o` is low for exactly `SWITCH_CYCLES` cycles and then goes high with the new owner. The new owner shows as active and as `active_id_o` from the first bubble cycle.
- R6: The next owner is the first ready context found by searching upward with wrap-around from the yielder's index plus one. A yielder that went to ready is considered last, so it is re-chosen only when no other context is ready, and it still pays the bubble.
- R7: A waiting context whose `done_i` bit is 1 is ready in the next cycle. Without that bit, it stays waiting.
- R8: If a yield finds no ready context, the block enters IDLE with valid low and no active context. In the cycle after some context turns ready, that context is granted. If several turn ready together, the same rotation from the last yielder applies. The bubble follows.
- R9: A `done_i` bit for a context that is not waiting leaves every state unchanged and sets `done_err_o` to 1 in the next cycle.
- R10: Yield bits are ignored during SWITCH and IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| yield_i | input | NUM_CTX | Per-context yield request, honoured only for the owner while valid is high |
| wait_i | input | NUM_CTX | Per-context park selector used with a yield: 1 = wait, 0 = ready |
| done_i | input | NUM_CTX | Per-context completion pulse from memory or a peripheral |
| active_id_o | output | $clog2(NUM_CTX) | Current owner, or the one being switched in. In IDLE it holds the last yielder |
| pipe_valid_o | output | 1 | High when the owner may issue |
| ctx_state_o | output | 2*NUM_CTX | Packed per-context state, two bits each |
| done_err_o | output | 1 | Pulse flagging a completion for a context that was not waiting |

## Verification
The hardest situation to reach is IDLE followed by a wake where two contexts turn ready in the same cycle. To get there, all eight contexts must be parked one after another, with a full bubble between each park. The bench walks the owner through eight parking yields and holds the completion lines low for several idle cycles. It then pulses two completions at once, so the rotation from the last yielder decides the grant. A long random phase, steered by the bench's own model of the owner, then mixes yields that park, yields that return to ready, stray completions and yields during bubbles.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

    typedef enum logic [1:0] {
        CTX_READY  = 2'd0,
        CTX_WAIT   = 2'd1,
        CTX_ACTIVE = 2'd2
    } ctx_state_e;

    typedef enum logic [1:0] {
        SCH_RUN    = 2'd0,
        SCH_SWITCH = 2'd1,
        SCH_IDLE   = 2'd2
    } sch_state_e;

endpackage

// File: rtl/tsched_rr_pick.sv
module tsched_rr_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] pick
);

    // Walk the offsets downward so that the smallest offset from start wins.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = int'(start) + k;
            if (idx >= N) begin
                idx = idx - N;
            end
            if (req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/tsched_ctx_slot.sv
module tsched_ctx_slot
    import tsched_pkg::*;
#(
    parameter bit START_ACTIVE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grant,
    input  logic       release_i,
    input  logic       park_wait,
    input  logic       done,
    output ctx_state_e state_o,
    output logic       err_o
);

    ctx_state_e state_q;
    ctx_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTX_READY: begin
                if (grant) state_d = CTX_ACTIVE;
            end
            CTX_WAIT: begin
                if (done) state_d = CTX_READY;
            end
            CTX_ACTIVE: begin
                if (release_i && !grant) begin
                    state_d = park_wait ? CTX_WAIT : CTX_READY;
                end
            end
            default: state_d = CTX_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= START_ACTIVE ? CTX_ACTIVE : CTX_READY;
            err_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_o   <= done && (state_q != CTX_WAIT);
        end
    end

    assign state_o = state_q;

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTX_WAIT && !done) |=> (state_q == CTX_WAIT));

    // R7
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTX_WAIT && done) |=> (state_q == CTX_READY));

    // R9
    stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state_q != CTX_WAIT) |=> err_o);

endmodule

// File: rtl/tsched_ctrl.sv
module tsched_ctrl
    import tsched_pkg::*;
#(
    parameter int N      = 8,
    parameter int IW     = 3,
    parameter int SW_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ready_vec,
    input  logic [N-1:0]  yield_vec,
    input  logic [N-1:0]  wait_vec,
    output logic [N-1:0]  grant_vec,
    output logic [N-1:0]  release_vec,
    output logic          park_wait,
    output logic [IW-1:0] active_id,
    output logic          pipe_valid
);

    localparam int CW = (SW_CYC > 1) ? $clog2(SW_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(SW_CYC - 1);

    sch_state_e    sch_q, sch_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] id_q;
    logic [IW-1:0] base;
    logic [N-1:0]  self_vec;
    logic [N-1:0]  cand;
    logic          yield_hit;
    logic          found;
    logic [IW-1:0] pick;
    logic          select;

    assign yield_hit = (sch_q == SCH_RUN) && yield_vec[id_q];
    assign base      = (id_q == IW'(N - 1)) ? '0 : id_q + 1'b1;
    assign self_vec  = N'(1) << id_q;

    always_comb begin
        unique case (sch_q)
            SCH_RUN:  cand = yield_hit ? (ready_vec | (wait_vec[id_q] ? '0 : self_vec)) : '0;
            SCH_IDLE: cand = ready_vec;
            default:  cand = '0;
        endcase
    end

    tsched_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req   (cand),
        .start (base),
        .found (found),
        .pick  (pick)
    );

    assign select = found && (yield_hit || sch_q == SCH_IDLE);

    // next-state
    always_comb begin
        sch_d = sch_q;
        unique case (sch_q)
            SCH_RUN: begin
                if (yield_hit) sch_d = found ? SCH_SWITCH : SCH_IDLE;
            end
            SCH_SWITCH: begin
                if (cnt_q == '0) sch_d = SCH_RUN;
            end
            SCH_IDLE: begin
                if (found) sch_d = SCH_SWITCH;
            end
            default: sch_d = SCH_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sch_q <= SCH_RUN;
            cnt_q <= '0;
            id_q  <= '0;
        end else begin
            sch_q <= sch_d;
            if (select) begin
                cnt_q <= CNT_LOAD;
                id_q  <= pick;
            end else if (sch_q == SCH_SWITCH && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pipe_valid  = (sch_q == SCH_RUN);
        active_id   = id_q;
        park_wait   = wait_vec[id_q];
        grant_vec   = select ? (N'(1) << pick) : '0;
        release_vec = yield_hit ? self_vec : '0;
    end

    // Independent measure of the bubble length.
    logic [CW:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (pipe_valid || sch_q != SCH_SWITCH) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R3
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_valid && !yield_vec[active_id]) |=> (pipe_valid && $stable(active_id)));

    // R5
    bubble_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_valid && yield_vec[active_id]) |=> !pipe_valid);

    // R5
    bubble_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pipe_valid) |-> (gap_q == (CW+1)'(SW_CYC)));

    // R8
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_q == SCH_IDLE && ready_vec != '0) |=> (sch_q == SCH_SWITCH));

    // R10
    quiet_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_q == SCH_SWITCH) |-> (grant_vec == '0 && release_vec == '0));

endmodule

// File: rtl/hw_thread_sched.sv
module hw_thread_sched
    import tsched_pkg::*;
#(
    parameter int NUM_CTX       = 8,
    parameter int SWITCH_CYCLES = 4,
    localparam int IW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CTX-1:0]   yield_i,
    input  logic [NUM_CTX-1:0]   wait_i,
    input  logic [NUM_CTX-1:0]   done_i,
    output logic [IW-1:0]        active_id_o,
    output logic                 pipe_valid_o,
    output logic [2*NUM_CTX-1:0] ctx_state_o,
    output logic                 done_err_o
);

    ctx_state_e         st [NUM_CTX];
    logic [NUM_CTX-1:0] ready_vec;
    logic [NUM_CTX-1:0] active_mask;
    logic [NUM_CTX-1:0] err_vec;
    logic [NUM_CTX-1:0] grant_vec;
    logic [NUM_CTX-1:0] release_vec;
    logic               park_wait;

    tsched_ctrl #(.N(NUM_CTX), .IW(IW), .SW_CYC(SWITCH_CYCLES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_vec   (ready_vec),
        .yield_vec   (yield_i),
        .wait_vec    (wait_i),
        .grant_vec   (grant_vec),
        .release_vec (release_vec),
        .park_wait   (park_wait),
        .active_id   (active_id_o),
        .pipe_valid  (pipe_valid_o)
    );

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
        tsched_ctx_slot #(.START_ACTIVE(i == 0)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .grant     (grant_vec[i]),
            .release_i (release_vec[i]),
            .park_wait (park_wait),
            .done      (done_i[i]),
            .state_o   (st[i]),
            .err_o     (err_vec[i])
        );
        assign ready_vec[i]       = (st[i] == CTX_READY);
        assign active_mask[i]     = (st[i] == CTX_ACTIVE);
        assign ctx_state_o[2*i+:2] = st[i];
    end

    assign done_err_o = |err_vec;

    // R2
    one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_mask));

    // R5
    valid_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_valid_o |-> active_mask[active_id_o]);

    // R8
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_valid_o && active_mask == '0) |-> !(|grant_vec) || (ready_vec != '0));

endmodule

// File: tb/hw_thread_sched_test.sv
module hw_thread_sched_test;

    localparam int N  = 8;
    localparam int SW = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] yield_i = '0;
    logic [N-1:0] wait_i = '0;
    logic [N-1:0] done_i = '0;
    logic [2:0]   active_id_o;
    logic         pipe_valid_o;
    logic [2*N-1:0] ctx_state_o;
    logic         done_err_o;

    always #10 clk = ~clk;

    hw_thread_sched #(.NUM_CTX(N), .SWITCH_CYCLES(SW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .yield_i      (yield_i),
        .wait_i       (wait_i),
        .done_i       (done_i),
        .active_id_o  (active_id_o),
        .pipe_valid_o (pipe_valid_o),
        .ctx_state_o  (ctx_state_o),
        .done_err_o   (done_err_o)
    );

    // Model: 0 ready, 1 waiting, 2 active; run 0 RUN, 1 SWITCH, 2 IDLE
    int m_st [N];
    int m_run, m_cnt, m_id, m_err;
    int checks = 0;
    int fails = 0;
    string phase = "R1";

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_st[i] = (i == 0) ? 2 : 0;
        m_run = 0; m_cnt = 0; m_id = 0; m_err = 0;
    endtask

    task automatic model_step(input logic [N-1:0] y, input logic [N-1:0] w, input logic [N-1:0] d);
        int nst [N];
        int c;
        bit hit;
        int park;
        m_err = 0;
        for (int i = 0; i < N; i++) begin
            nst[i] = m_st[i];
            if (d[i]) begin
                if (m_st[i] == 1) nst[i] = 0;
                else m_err = 1;
            end
        end
        if (m_run == 0) begin
            if (y[m_id]) begin
                park = w[m_id] ? 1 : 0;
                hit = 0; c = 0;
                for (int k = 1; k <= N && !hit; k++) begin
                    c = (m_id + k) % N;
                    if (m_st[c] == 0 || (c == m_id && park == 0)) hit = 1;
                end
                if (hit) begin
                    if (c != m_id) begin
                        nst[m_id] = park;
                        nst[c] = 2;
                    end
                    m_id = c; m_run = 1; m_cnt = SW - 1;
                end else begin
                    nst[m_id] = park;
                    m_run = 2;
                end
            end
        end else if (m_run == 1) begin
            if (m_cnt == 0) m_run = 0;
            else m_cnt = m_cnt - 1;
        end else begin
            hit = 0; c = 0;
            for (int k = 1; k <= N && !hit; k++) begin
                c = (m_id + k) % N;
                if (m_st[c] == 0) hit = 1;
            end
            if (hit) begin
                nst[c] = 2; m_id = c; m_run = 1; m_cnt = SW - 1;
            end
        end
        for (int i = 0; i < N; i++) m_st[i] = nst[i];
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (phase %s) actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R6 active_id", int'(active_id_o), m_id);
        check("R5 pipe_valid", int'(pipe_valid_o), (m_run == 0) ? 1 : 0);
        check("R9 done_err", int'(done_err_o), m_err);
        for (int i = 0; i < N; i++)
            check("R2 ctx_state", int'(ctx_state_o[2*i+:2]), m_st[i]);
    endtask

    task automatic cyc(input logic [N-1:0] y, input logic [N-1:0] w, input logic [N-1:0] d);
        yield_i = y; wait_i = w; done_i = d;
        @(posedge clk);
        model_step(y, w, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic to_valid();
        while (m_run == 1) cyc('0, '0, '0);
    endtask

    function automatic logic [N-1:0] oh(input int i);
        return N'(1) << i;
    endfunction

    initial begin
        repeat (5) begin
            #200000000;
        end
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        compare_all();

        // Non-owner yields and lone wait bits do nothing.
        phase = "R3";
        for (int t = 0; t < 12; t++)
            cyc(~oh(m_id) & N'($urandom), N'($urandom), '0);

        // Yield back to ready: rotation through all contexts.
        phase = "R4";
        for (int t = 0; t < 10; t++) begin
            cyc(oh(m_id), '0, '0);
            to_valid();
        end

        // Yields while the bubble counts down.
        phase = "R10";
        cyc(oh(m_id), oh(m_id), '0);
        for (int t = 0; t < SW; t++) cyc('1, '0, '0);
        to_valid();

        // Park everyone, then sit idle and wake two at once.
        phase = "R8";
        for (int t = 0; t < N + 1; t++) begin
            if (m_run == 0) cyc(oh(m_id), '1, '0);
            to_valid();
        end
        for (int t = 0; t < 5; t++) cyc('1, '1, '0);
        cyc('0, '0, 8'b0100_1000);
        for (int t = 0; t < SW + 2; t++) cyc('0, '0, '0);

        // Completions to waiting contexts and stray ones.
        phase = "R7";
        for (int i = 0; i < N; i++) cyc('0, '0, oh(i));
        cyc('0, '0, '1);
        cyc('0, '0, '0);

        // Long mixed phase.
        phase = "R6";
        for (int t = 0; t < 4000; t++) begin
            logic [N-1:0] y, w, d;
            y = '0;
            if ($urandom_range(0, 3) == 0) y = oh(m_id);
            if ($urandom_range(0, 5) == 0) y = y | N'($urandom);
            w = ($urandom_range(0, 2) != 0) ? '1 : '0;
            d = '0;
            for (int i = 0; i < N; i++)
                if (m_st[i] == 1 && $urandom_range(0, 7) == 0) d[i] = 1'b1;
            if ($urandom_range(0, 30) == 0) d[$urandom_range(0, N-1)] = 1'b1;
            cyc(y, w, d);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule